// File: doc/BRIEF.md
# Four-Beat Burst DRAM Read Sequencer

This block turns a single read request into the strobe sequence of a four-beat burst read from a DRAM-style memory. A request carries a start address and a one-bit timing-mode select. The upper address bits name the memory row. The lower bits name the column, and the sequencer forces that column to a multiple of four so that a burst never leaves its row. After it accepts a request, the block opens the row with a one-cycle row strobe. It then issues column strobes and raises a beat-valid strobe once for each of the four data beats. With each beat it presents the beat index and the column address.

Two timing profiles are built in. In the spaced profile (mode 0) the beats arrive 5, 2, 2 and 2 cycles apart, and every beat has its own column strobe. In the streaming profile (mode 1) the beats arrive 7, 1, 1 and 1 cycles apart, and one column strobe serves the whole burst. A done pulse marks the last beat. Between acceptance and that pulse the sequencer reports itself busy.

The controller has four states. `S_IDLE` waits for a request. `S_ROW` is the row-strobe cycle. `S_WAIT` covers the cycles that carry no beat. `S_BEAT` is a cycle that carries a beat. The transitions are:
- `S_IDLE` to `S_ROW` on acceptance.
- `S_ROW` to `S_WAIT`, or to `S_BEAT` when the next cycle is a beat.
- `S_WAIT` to `S_BEAT` when the next cycle is a beat.
- `S_BEAT` back to `S_BEAT` when the gap is one cycle, or to `S_WAIT` when the gap is longer.
- `S_BEAT` to `S_IDLE` after the fourth beat.

Top module: `burst_seq`

## Requirements
- R1: A request (`req_valid` high) is accepted at a rising edge only while `ready` is high. `ready` is then low from the first cycle after acceptance through the cycle that carries `done`, and high again in the next cycle.
- R2: Counting the first cycle after acceptance as cycle 1, `row_stb` is high in cycle 1 only. `row_addr` equals the start address bits above the column field for the whole burst.
- R3: In mode 0, `beat_valid` is high in cycles 5, 7, 9 and 11 and in no other cycle of the burst.
- R4: In mode 0, `col_stb` is high in cycles 4, 6, 8 and 10 only. Each pulse is one cycle wide and comes one cycle before a beat, with `col_addr` already showing that beat's column.
- R5: In mode 1, `beat_valid` is high in cycles 7, 8, 9 and 10 and in no other cycle of the burst.
- R6: In mode 1, `col_stb` is high in cycle 3 only, with `col_addr` showing the first beat's column.
- R7: During beat k (k = 0..3), `beat_idx` equals k and `col_addr` equals the start column with its two low bits cleared, plus k. The two low address bits of the request have no effect.
- R8: `done` is high in the cycle of the fourth beat only, so a burst lasts 11 cycles in mode 0 and 10 cycles in mode 1. The block is idle in the cycle after `done`.
- R9: A synchronous active-high `rst` returns the block to idle: `ready` high, and `row_stb`, `col_stb`, `beat_valid` and `done` low, even in the middle of a burst.
- R10: A request held high while the block is busy changes neither the burst in progress nor its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Burst request |
| req_mode | input | 1 | Timing profile: 0 spaced, 1 streaming |
| req_addr | input | ROW_W+COL_W | Start address, row bits above column bits |
| ready | output | 1 | Idle and able to accept a request |
| row_stb | output | 1 | Row strobe pulse |
| col_stb | output | 1 | Column strobe pulse |
| row_addr | output | ROW_W | Row of the current burst |
| col_addr | output | COL_W | Column of the current or upcoming beat |
| beat_valid | output | 1 | Data beat strobe |
| beat_idx | output | 2 | Index of the current beat |
| done | output | 1 | Last beat of the burst |

## Verification
Every start address of the default 8-bit configuration is swept in both modes. Each cycle of each burst is compared with strobe positions that are computed arithmetically from the 5-2-2-2 and 7-1-1-1 patterns. Addresses with nonzero low bits separate correct alignment from pass-through of those bits. A request held high with different contents during every burst separates proper busy gating from re-acceptance. A reset in the middle of a burst, and bursts issued back to back, check that the block returns to idle and restarts cleanly.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ROW,
        S_WAIT,
        S_BEAT
    } seq_state_t;

    localparam logic MODE_SPACED = 1'b0;
    localparam logic MODE_STREAM = 1'b1;

    localparam int BEATS = 4;

endpackage

// File: rtl/burst_seq_profile.sv
module burst_seq_profile #(
    parameter int CNT_W     = 4,
    parameter int SP_FIRST  = 5,
    parameter int SP_GAP    = 2,
    parameter int ST_FIRST  = 7,
    parameter int ST_GAP    = 1,
    parameter int ST_CAS_AT = 3
) (
    input  logic             mode,
    output logic [CNT_W-1:0] first,
    output logic [CNT_W-1:0] gap,
    output logic [CNT_W-1:0] cas_at,
    output logic             cas_each
);
    import burst_seq_pkg::*;

    // Cycle offsets of each profile, counted from the row-strobe cycle (cycle 1)
    always_comb begin
        if (mode == MODE_SPACED) begin
            first    = CNT_W'(SP_FIRST);
            gap      = CNT_W'(SP_GAP);
            cas_at   = '0;
            cas_each = 1'b1;
        end else begin
            first    = CNT_W'(ST_FIRST);
            gap      = CNT_W'(ST_GAP);
            cas_at   = CNT_W'(ST_CAS_AT);
            cas_each = 1'b0;
        end
    end

endmodule

// File: rtl/burst_seq_counters.sv
module burst_seq_counters #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             beat,
    input  logic [CNT_W-1:0] first,
    input  logic [CNT_W-1:0] gap,
    output logic [CNT_W-1:0] elapsed,
    output logic [CNT_W-1:0] next_at,
    output logic [1:0]       beat_cnt
);

    // elapsed: cycle number within the burst; next_at: cycle of the next beat
    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed  <= '0;
            next_at  <= '0;
            beat_cnt <= '0;
        end else if (start) begin
            elapsed  <= CNT_W'(1);
            next_at  <= first;
            beat_cnt <= '0;
        end else begin
            elapsed <= elapsed + CNT_W'(1);
            if (beat) begin
                next_at  <= next_at + gap;
                beat_cnt <= beat_cnt + 2'd1;
            end
        end
    end

endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
    parameter int ROW_W     = 4,
    parameter int COL_W     = 4,
    parameter int SP_FIRST  = 5,
    parameter int SP_GAP    = 2,
    parameter int ST_FIRST  = 7,
    parameter int ST_GAP    = 1,
    parameter int ST_CAS_AT = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_mode,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    output logic                   ready,
    output logic                   row_stb,
    output logic                   col_stb,
    output logic [ROW_W-1:0]       row_addr,
    output logic [COL_W-1:0]       col_addr,
    output logic                   beat_valid,
    output logic [1:0]             beat_idx,
    output logic                   done
);
    import burst_seq_pkg::*;

    localparam int ADDR_W  = ROW_W + COL_W;
    localparam int SP_END  = SP_FIRST + (BEATS - 1) * SP_GAP;
    localparam int ST_END  = ST_FIRST + (BEATS - 1) * ST_GAP;
    localparam int LONGEST = (SP_END > ST_END) ? SP_END : ST_END;
    localparam int CNT_W   = $clog2(LONGEST + 2);

    seq_state_t state, state_nx;

    logic              mode_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  base_q;
    logic              accept;
    logic              mode_sel;
    logic [CNT_W-1:0]  first, gap, cas_at;
    logic              cas_each;
    logic [CNT_W-1:0]  elapsed, next_at;
    logic [1:0]        beat_cnt;
    logic              hit;
    logic              last;

    assign accept   = req_valid && (state == S_IDLE);
    assign mode_sel = accept ? req_mode : mode_q;

    burst_seq_profile #(
        .CNT_W    (CNT_W),
        .SP_FIRST (SP_FIRST),
        .SP_GAP   (SP_GAP),
        .ST_FIRST (ST_FIRST),
        .ST_GAP   (ST_GAP),
        .ST_CAS_AT(ST_CAS_AT)
    ) u_profile (
        .mode    (mode_sel),
        .first   (first),
        .gap     (gap),
        .cas_at  (cas_at),
        .cas_each(cas_each)
    );

    burst_seq_counters #(
        .CNT_W(CNT_W)
    ) u_counters (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .beat    (state == S_BEAT),
        .first   (first),
        .gap     (gap),
        .elapsed (elapsed),
        .next_at (next_at),
        .beat_cnt(beat_cnt)
    );

    // Request capture; the column is aligned to a four-beat boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_SPACED;
            row_q  <= '0;
            base_q <= '0;
        end else if (accept) begin
            mode_q <= req_mode;
            row_q  <= req_addr[ADDR_W-1:COL_W];
            base_q <= {req_addr[COL_W-1:2], 2'b00};
        end
    end

    // The next cycle carries a beat
    assign hit  = (state != S_IDLE) && (state != S_BEAT) &&
                  ((elapsed + CNT_W'(1)) == next_at);
    assign last = (beat_cnt == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (accept) state_nx = S_ROW;
            S_ROW:  state_nx = hit ? S_BEAT : S_WAIT;
            S_WAIT: if (hit) state_nx = S_BEAT;
            S_BEAT: begin
                if (last)                    state_nx = S_IDLE;
                else if (gap == CNT_W'(1))   state_nx = S_BEAT;
                else                         state_nx = S_WAIT;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        ready      = (state == S_IDLE);
        row_stb    = (state == S_ROW);
        beat_valid = (state == S_BEAT);
        done       = (state == S_BEAT) && last;
        if (cas_each) col_stb = hit;
        else          col_stb = (state != S_IDLE) && (elapsed == cas_at);
        row_addr   = row_q;
        col_addr   = base_q | COL_W'(beat_cnt);
        beat_idx   = beat_cnt;
    end

    // R8: done only on the fourth beat
    a_r8_done_on_last: assert property (@(posedge clk) disable iff (rst)
        done |-> (beat_valid && beat_idx == 2'd3));

    // R8: idle right after done
    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> ready);

    // R1: busy only after a request was presented
    a_r1_ready_drop: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(req_valid));

    // R2: row strobe is a single-cycle pulse
    a_r2_row_pulse: assert property (@(posedge clk) disable iff (rst)
        row_stb |=> !row_stb);

    // R4: in the spaced profile each column strobe is followed by a beat
    a_r4_cas_leads_beat: assert property (@(posedge clk) disable iff (rst)
        (col_stb && mode_q == MODE_SPACED) |=> beat_valid);

    // R5: streaming beats follow back to back
    a_r5_stream_back: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !done && mode_q == MODE_STREAM) |=> beat_valid);

    // R9: after reset the block is idle with strobes low
    a_r9_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (ready && !row_stb && !col_stb && !beat_valid && !done));

endmodule

// File: tb/burst_seq_bench.sv
module burst_seq_bench;

    localparam int ROW_W  = 4;
    localparam int COL_W  = 4;
    localparam int ADDR_W = ROW_W + COL_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_mode;
    logic [ADDR_W-1:0] req_addr;
    logic              ready, row_stb, col_stb, beat_valid, done;
    logic [ROW_W-1:0]  row_addr;
    logic [COL_W-1:0]  col_addr;
    logic [1:0]        beat_idx;

    int n_vec  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    burst_seq #(.ROW_W(ROW_W), .COL_W(COL_W)) u_burst_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .req_addr(req_addr), .ready(ready), .row_stb(row_stb),
        .col_stb(col_stb), .row_addr(row_addr), .col_addr(col_addr),
        .beat_valid(beat_valid), .beat_idx(beat_idx), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Called at a negedge with ready expected high
    task automatic run_burst(input logic mode, input logic [ADDR_W-1:0] addr);
        int nlen;
        logic [ROW_W-1:0] erow;
        logic [COL_W-1:0] ecol;
        nlen = (mode == 1'b0) ? 11 : 10;
        erow = addr[ADDR_W-1:COL_W];
        ecol = {addr[COL_W-1:2], 2'b00};
        chk(ready == 1'b1, "R1", int'(ready), 1);
        req_valid = 1'b1;
        req_mode  = mode;
        req_addr  = addr;
        for (int c = 1; c <= nlen + 1; c++) begin
            bit eb, ec;
            int k;
            @(negedge clk);
            // R10: a differing request stays asserted while busy
            req_mode = ~mode;
            req_addr = ~addr;
            if (c >= nlen) req_valid = 1'b0;
            if (c > nlen) begin
                chk(ready == 1'b1, "R8", int'(ready), 1);
                chk(!row_stb && !col_stb && !beat_valid && !done, "R8",
                    int'({row_stb, col_stb, beat_valid, done}), 0);
            end else begin
                if (mode == 1'b0) begin
                    eb = (c >= 5) && (c % 2 == 1);
                    ec = (c >= 4) && (c <= 10) && (c % 2 == 0);
                    k  = eb ? (c - 5) / 2 : (c - 4) / 2;
                    chk(beat_valid == eb, "R3", int'(beat_valid), int'(eb));
                    chk(col_stb == ec, "R4", int'(col_stb), int'(ec));
                    if (ec) chk(col_addr == ecol + COL_W'(k), "R4",
                                int'(col_addr), int'(ecol) + k);
                end else begin
                    eb = (c >= 7);
                    ec = (c == 3);
                    k  = eb ? c - 7 : 0;
                    chk(beat_valid == eb, "R5", int'(beat_valid), int'(eb));
                    chk(col_stb == ec, "R6", int'(col_stb), int'(ec));
                    if (ec) chk(col_addr == ecol, "R6", int'(col_addr), int'(ecol));
                end
                chk(ready == 1'b0, "R1", int'(ready), 0);
                chk(row_stb == (c == 1), "R2", int'(row_stb), int'(c == 1));
                chk(row_addr == erow, "R10", int'(row_addr), int'(erow));
                chk(done == (c == nlen), "R8", int'(done), int'(c == nlen));
                if (eb) begin
                    chk(beat_idx == 2'(k), "R7", int'(beat_idx), k);
                    chk(col_addr == ecol + COL_W'(k), "R7", int'(col_addr), int'(ecol) + k);
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_mode = 1'b0; req_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk(ready && !row_stb && !col_stb && !beat_valid && !done, "R9",
            int'({ready, row_stb, col_stb, beat_valid, done}), 16);
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < (1 << ADDR_W); a++)
                run_burst(1'(m), ADDR_W'(a));
        // R9: reset in the middle of a burst
        req_valid = 1'b1; req_mode = 1'b1; req_addr = 8'h5A;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(ready && !row_stb && !col_stb && !beat_valid && !done, "R9",
            int'({ready, row_stb, col_stb, beat_valid, done}), 16);
        @(negedge clk);
        chk(ready && !beat_valid, "R9", int'({ready, beat_valid}), 2);
        // Clean restart after the abort
        run_burst(1'b0, 8'hC7);
        run_burst(1'b1, 8'h3E);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule